// File: doc/BRIEF.md
# Idle State Request Coordinator

This block merges the low-power idle requests of the hardware threads of one core into a single core idle state. Each thread can issue a request from one of three sources:

- a wait request that carries a state hint,
- a halt,
- a legacy read of a clock-control I/O register.

When legacy redirection is enabled, the block turns those I/O reads into the equivalent wait-hint requests and consumes them. When redirection is off, the reads are handed to an I/O-forward output and change no state.

Each thread keeps its own registered state. A thread may only leave the active state C0 for an idle state, and may only leave an idle state by waking back to C0. The core state is the shallowest of the thread states and is registered one cycle after the thread states. If enhanced C1 is enabled and the other cores all report C1 or deeper at the moment of entry, a core that resolves to C1 is reported as C1E. The core holds its idle state until it resolves back to C0.

Top module: `idle_coord`

## Requirements
- R1: After reset every thread state, the core state and every I/O-forward bit are 0. The state codes are C0=0, C1=1, C1E=2, C3=3 and C6=4, each 3 bits wide.
- R2: A thread's request is decoded from its source code (0=wait, 1=halt, 2=legacy I/O read, 3=reserved with no effect). A thread in C0 that issues a halt, or a wait with hint 1, is in C1 on the next clock.
- R3: A wait hint of 3 gives C3 and a hint of 4 gives C6. Any other hint value (0, 2, 5, 6, 7) is treated as C1.
- R4: With redirection enabled, a legacy read gives C3 when argument bit 0 is 0 and C6 when it is 1. The I/O-forward bit stays 0.
- R5: With redirection disabled, a legacy read sets that thread's I/O-forward bit for exactly the following cycle and leaves the thread state unchanged.
- R6: A thread that is not in C0 ignores every new idle request. It never moves directly between two idle states.
- R7: A wake input returns its thread to C0 on the next clock, even if an idle request is presented in the same cycle.
- R8: The core state equals the numerically smallest (shallowest) thread state and appears one clock after the thread states change. If any thread is in C0, the core is in C0.
- R9: When the core moves from C0 to a resolved C1, it reports C1E if enhanced C1 is enabled and the other-cores-deep input is high in that cycle. Otherwise it reports C1.
- R10: While the core is idle and the resolved state is not C0, the core state holds, including its C1/C1E choice, whatever the enhanced-C1 inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NUM_THREADS | Per-thread request strobe |
| req_src_i | input | 2*NUM_THREADS | Per-thread request source code |
| req_arg_i | input | 3*NUM_THREADS | Per-thread wait hint or legacy level (bit 0) |
| wake_i | input | NUM_THREADS | Per-thread wake event |
| redirect_en_i | input | 1 | Enables translation of legacy I/O reads |
| c1e_en_i | input | 1 | Enables C1-to-C1E promotion |
| others_deep_i | input | 1 | All other cores at C1 or deeper |
| thread_state_o | output | 3*NUM_THREADS | Per-thread state codes |
| core_state_o | output | 3 | Resolved core state code |
| io_fwd_o | output | NUM_THREADS | Per-thread pulse: legacy read forwarded to the system |

## Verification
The bench builds the block with its default parameters: two threads and 3-bit state codes. These values give the full thread-pair combinations of the coordination rule, including the mixed C1/C3/C6 cases and the case where both threads are in C6. With two threads, one thread can be held idle while the other wakes and re-enters. This checks that the core only changes idle depth through C0, and that the C1E decision is frozen at entry.

// File: rtl/idle_pkg.sv
package idle_pkg;
    localparam int STATE_W = 3;
    localparam int SRC_W   = 2;
    localparam int ARG_W   = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_C0  = 3'd0,
        ST_C1  = 3'd1,
        ST_C1E = 3'd2,
        ST_C3  = 3'd3,
        ST_C6  = 3'd4
    } cstate_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_WAIT   = 2'd0,
        SRC_HALT   = 2'd1,
        SRC_LEGACY = 2'd2,
        SRC_RSVD   = 2'd3
    } src_e;
endpackage

// File: rtl/idle_req_decode.sv
module idle_req_decode
    import idle_pkg::*;
(
    input  logic             req_valid,
    input  logic [SRC_W-1:0] req_src,
    input  logic [ARG_W-1:0] req_arg,
    input  logic             redirect_en,
    output logic             idle_go,
    output cstate_e          idle_target,
    output logic             fwd_req
);
    always_comb begin
        idle_go     = 1'b0;
        idle_target = ST_C1;
        fwd_req     = 1'b0;
        if (req_valid) begin
            unique case (src_e'(req_src))
                SRC_WAIT: begin
                    idle_go = 1'b1;
                    // R3: unsupported hints fall back to C1
                    unique case (req_arg)
                        3'd3:    idle_target = ST_C3;
                        3'd4:    idle_target = ST_C6;
                        default: idle_target = ST_C1;
                    endcase
                end
                SRC_HALT: begin
                    idle_go     = 1'b1;
                    idle_target = ST_C1;
                end
                SRC_LEGACY: begin
                    if (redirect_en) begin
                        idle_go     = 1'b1;
                        idle_target = req_arg[0] ? ST_C6 : ST_C3;
                    end else begin
                        fwd_req = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/idle_thread_fsm.sv
module idle_thread_fsm
    import idle_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wake,
    input  logic    idle_go,
    input  cstate_e idle_target,
    input  logic    fwd_req,
    output cstate_e state_o,
    output logic    fwd_o
);
    typedef struct packed {
        cstate_e st;
        logic    fwd;
    } thr_t;

    thr_t thr_d, thr_q;

    always_comb begin
        thr_d     = thr_q;
        thr_d.fwd = fwd_req;
        if (wake) begin
            thr_d.st = ST_C0;
        end else if (thr_q.st == ST_C0 && idle_go) begin
            thr_d.st = idle_target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '{st: ST_C0, fwd: 1'b0};
        end else begin
            thr_q <= thr_d;
        end
    end

    assign state_o = thr_q.st;
    assign fwd_o   = thr_q.fwd;

    // R6
    thr_no_idle_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != ST_C0) |=> ($stable(state_o) || state_o == ST_C0));
    // R7
    thr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (state_o == ST_C0));
    // R2
    thr_never_c1e_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != ST_C1E);
    // R5
    thr_fwd_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_req && !idle_go && !wake) |=> (fwd_o && $stable(state_o)));
endmodule

// File: rtl/idle_core_resolve.sv
module idle_core_resolve
    import idle_pkg::*;
#(
    parameter int NUM_THREADS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_THREADS*STATE_W-1:0] thread_states,
    input  logic                           c1e_en,
    input  logic                           others_deep,
    output cstate_e                        core_o
);
    typedef struct packed {
        cstate_e st;
    } core_t;

    core_t                core_d, core_q;
    logic [STATE_W-1:0]   shallow;
    logic                 any_c0;
    cstate_e              resolved;

    always_comb begin
        shallow = STATE_W'(ST_C6);
        any_c0  = 1'b0;
        for (int i = 0; i < NUM_THREADS; i++) begin
            if (thread_states[i*STATE_W +: STATE_W] < shallow)
                shallow = thread_states[i*STATE_W +: STATE_W];
            if (thread_states[i*STATE_W +: STATE_W] == STATE_W'(ST_C0))
                any_c0 = 1'b1;
        end
        resolved = cstate_e'(shallow);
        if (resolved == ST_C1 && c1e_en && others_deep)
            resolved = ST_C1E;

        core_d = core_q;
        if (core_q.st == ST_C0 || resolved == ST_C0)
            core_d.st = resolved;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '{st: ST_C0};
        end else begin
            core_q <= core_d;
        end
    end

    assign core_o = core_q.st;

    // R8
    core_follows_c0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_c0 |=> (core_o == ST_C0));
    // R10
    core_no_idle_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_o != ST_C0 && !any_c0) |=> $stable(core_o));
    // R9
    core_c1e_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_o == ST_C0 && !(c1e_en && others_deep)) |=> (core_o != ST_C1E));
endmodule

// File: rtl/idle_coord.sv
module idle_coord
    import idle_pkg::*;
#(
    parameter int NUM_THREADS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_THREADS-1:0]         req_valid_i,
    input  logic [NUM_THREADS*SRC_W-1:0]   req_src_i,
    input  logic [NUM_THREADS*ARG_W-1:0]   req_arg_i,
    input  logic [NUM_THREADS-1:0]         wake_i,
    input  logic                           redirect_en_i,
    input  logic                           c1e_en_i,
    input  logic                           others_deep_i,
    output logic [NUM_THREADS*STATE_W-1:0] thread_state_o,
    output logic [STATE_W-1:0]             core_state_o,
    output logic [NUM_THREADS-1:0]         io_fwd_o
);
    cstate_e core_st;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic    go, fwd;
        cstate_e tgt, st;

        idle_req_decode u_dec (
            .req_valid   (req_valid_i[t]),
            .req_src     (req_src_i[t*SRC_W +: SRC_W]),
            .req_arg     (req_arg_i[t*ARG_W +: ARG_W]),
            .redirect_en (redirect_en_i),
            .idle_go     (go),
            .idle_target (tgt),
            .fwd_req     (fwd)
        );

        idle_thread_fsm u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .wake        (wake_i[t]),
            .idle_go     (go),
            .idle_target (tgt),
            .fwd_req     (fwd),
            .state_o     (st),
            .fwd_o       (io_fwd_o[t])
        );

        assign thread_state_o[t*STATE_W +: STATE_W] = st;
    end

    idle_core_resolve #(.NUM_THREADS(NUM_THREADS)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .thread_states (thread_state_o),
        .c1e_en        (c1e_en_i),
        .others_deep   (others_deep_i),
        .core_o        (core_st)
    );

    assign core_state_o = core_st;

    // R4
    redirect_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|io_fwd_o) |-> !$past(redirect_en_i));
endmodule

// File: tb/idle_coord_tb.sv
module idle_coord_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req_valid_i = '0;
    logic [3:0] req_src_i = '0;
    logic [5:0] req_arg_i = '0;
    logic [1:0] wake_i = '0;
    logic       redirect_en_i = 1'b0;
    logic       c1e_en_i = 1'b0;
    logic       others_deep_i = 1'b0;
    logic [5:0] thread_state_o;
    logic [2:0] core_state_o;
    logic [1:0] io_fwd_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    idle_coord u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_src_i(req_src_i),
        .req_arg_i(req_arg_i), .wake_i(wake_i), .redirect_en_i(redirect_en_i),
        .c1e_en_i(c1e_en_i), .others_deep_i(others_deep_i),
        .thread_state_o(thread_state_o), .core_state_o(core_state_o), .io_fwd_o(io_fwd_o)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] ts(int t);
        return thread_state_o[t*3 +: 3];
    endfunction

    // one-cycle request; on return the thread register has updated
    task automatic issue(int t, logic [1:0] src, logic [2:0] arg);
        @(negedge clk);
        req_valid_i[t] = 1'b1;
        req_src_i[t*2 +: 2] = src;
        req_arg_i[t*3 +: 3] = arg;
        @(negedge clk);
        req_valid_i[t] = 1'b0;
    endtask

    task automatic wake_all();
        @(negedge clk);
        wake_i = 2'b11;
        @(negedge clk);
        wake_i = 2'b00;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 thread0", ts(0), 3'd0);
        chk("R1 thread1", ts(1), 3'd0);
        chk("R1 core", core_state_o, 3'd0);
        chk("R1 iofwd", {1'b0, io_fwd_o}, 3'd0);
    endtask

    task automatic t_halt();
        issue(0, 2'd1, 3'd0);
        chk("R2 halt", ts(0), 3'd1);
        @(negedge clk);
        chk("R8 core C0 while t1 active", core_state_o, 3'd0);
        wake_all();
        issue(1, 2'd0, 3'd1);
        chk("R2 wait hint1", ts(1), 3'd1);
        issue(0, 2'd3, 3'd4);
        chk("R2 reserved src", ts(0), 3'd0);
        wake_all();
    endtask

    task automatic t_hints();
        for (int h = 0; h < 8; h++) begin
            logic [2:0] exp;
            exp = (h == 3) ? 3'd3 : (h == 4) ? 3'd4 : 3'd1;
            issue(0, 2'd0, 3'(h));
            chk($sformatf("R3 hint %0d", h), ts(0), exp);
            wake_all();
        end
    endtask

    task automatic t_legacy();
        redirect_en_i = 1'b1;
        issue(0, 2'd2, 3'd0);
        chk("R4 level2", ts(0), 3'd3);
        chk("R4 no fwd", {1'b0, io_fwd_o}, 3'd0);
        wake_all();
        issue(1, 2'd2, 3'd1);
        chk("R4 level3", ts(1), 3'd4);
        wake_all();
        redirect_en_i = 1'b0;
        issue(1, 2'd2, 3'd1);
        chk("R5 fwd pulse", {1'b0, io_fwd_o}, 3'd2);
        chk("R5 state kept", ts(1), 3'd0);
        @(negedge clk);
        chk("R5 pulse ends", {1'b0, io_fwd_o}, 3'd0);
        redirect_en_i = 1'b1;
    endtask

    task automatic t_ignore();
        issue(0, 2'd0, 3'd3);
        issue(0, 2'd1, 3'd0);
        chk("R6 C3 ignores halt", ts(0), 3'd3);
        issue(0, 2'd0, 3'd4);
        chk("R6 C3 ignores C6", ts(0), 3'd3);
        wake_all();
    endtask

    task automatic t_wake_prio();
        @(negedge clk);
        req_valid_i[0] = 1'b1;
        req_src_i[1:0] = 2'd1;
        wake_i[0] = 1'b1;
        @(negedge clk);
        req_valid_i[0] = 1'b0;
        wake_i[0] = 1'b0;
        chk("R7 wake wins", ts(0), 3'd0);
    endtask

    task automatic t_core();
        issue(0, 2'd0, 3'd3);
        issue(1, 2'd0, 3'd4);
        @(negedge clk);
        chk("R8 C3+C6", core_state_o, 3'd3);
        @(negedge clk);
        wake_i[0] = 1'b1;
        @(negedge clk);
        wake_i[0] = 1'b0;
        @(negedge clk);
        chk("R8 core back to C0", core_state_o, 3'd0);
        issue(0, 2'd0, 3'd4);
        @(negedge clk);
        chk("R8 C6+C6", core_state_o, 3'd4);
        wake_all();
        chk("R8 after wake", core_state_o, 3'd0);
    endtask

    task automatic t_c1e();
        c1e_en_i = 1'b1;
        others_deep_i = 1'b1;
        issue(0, 2'd1, 3'd0);
        issue(1, 2'd0, 3'd3);
        @(negedge clk);
        chk("R9 promote", core_state_o, 3'd2);
        others_deep_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 C1E held", core_state_o, 3'd2);
        wake_all();
        issue(0, 2'd1, 3'd0);
        issue(1, 2'd1, 3'd0);
        @(negedge clk);
        chk("R9 no promote others shallow", core_state_o, 3'd1);
        others_deep_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 C1 held", core_state_o, 3'd1);
        wake_all();
        c1e_en_i = 1'b0;
        issue(0, 2'd1, 3'd0);
        issue(1, 2'd1, 3'd0);
        @(negedge clk);
        chk("R9 disabled", core_state_o, 3'd1);
        wake_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        redirect_en_i = 1'b1;
        t_halt();
        t_hints();
        t_legacy();
        t_ignore();
        t_wake_prio();
        t_core();
        t_c1e();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule